// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service Sequence

This block is a supervisory timer that sits on a simple word-addressed register bus with separate write and read strobes and 32-bit data. A fixed prescaler divides the clock by four. Each prescaled tick moves a 24-bit down counter one step. Software keeps the system alive by writing a two-value key to the service register, and that reloads the counter from a programmable timeout constant.

Setting the enable bit does not start the guard by itself. The guard becomes live only when a complete, correct key sequence follows the enable. From then on it cannot be stopped until the next system reset. A counter that runs out, or a key whose second half is wrong, trips the block. A trip sets a sticky expiry flag and, when reset generation is selected, emits a one-cycle reset request to the system reset logic.

The register layout uses word addresses. Address 0 is control/status. Address 1 is the timeout constant. Address 2 is the service (key) register. Address 3 is the live count.

Top module: `wdg_timer`

## Requirements
- R1: After reset the control/status register reads 0, the timeout constant and the live count both read 0x000000FF, and `rst_req` is low.
- R2: A write to address 1 keeps `wdata[23:0]` and ignores bits 31:24. A value below 0xFF is stored as 0xFF. Readback returns the stored value zero-extended.
- R3: Control bit 0 (enable) and bit 1 (reset select) can only be set by writing 1; writing 0 leaves them set. Bit 2 (expiry flag) is read-only, and writes to it have no effect.
- R4: While the guard is not live, the live count does not change except through a reload. A valid key written before enable is set does not make the guard live.
- R5: Once live, the count decreases by exactly one every four clock cycles.
- R6: A valid key is a write of 0xAA to address 2, followed by a write of 0x55 to address 2 as the very next bus access, with only `wdata[7:0]` compared. Its second write reloads the live count from the timeout constant, whether or not the guard is live.
- R7: When a live guard's count steps from 1 to 0, the count then stays at 0 and control bit 2 becomes 1. If reset select is set, `rst_req` is high for exactly one cycle.
- R8: An expiry with reset select clear sets the flag but never raises `rst_req`.
- R9: On a live guard, 0xAA followed by any other value written to address 2 trips the block at once. The flag is set, and with reset select set, `rst_req` is high in the cycle after the bad write. On a guard that is not live, the same writes have no effect.
- R10: Any other bus access between the two key writes (a read of any address, or a write to another address) cancels the sequence. The following 0x55 then neither reloads nor trips.
- R11: `rdata` reflects `addr` combinationally. Address 2 reads 0, and address 3 returns the 24-bit count with bits 31:24 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| addr | input | 2 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| rst_req | output | 1 | One-cycle reset request on a trip |

## Verification
The checker assumes the bus raises at most one of `wr_en` and `rd_en` per cycle. It also assumes two trips never fall on consecutive cycles, so a reset request is a lone pulse. The tasks drive one access per cycle and change inputs only on the falling edge. Each scenario ends with a system reset, which stays well away from a second trip. Counting checks sample the live count across exact multiples of the four-cycle tick window, so the prescaler phase never matters.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // word addresses of the registers
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_TC   = 1;
   localparam int unsigned REG_KEY  = 2;
   localparam int unsigned REG_CNT  = 3;

   // control register bit positions
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_RSEL = 1;
   localparam int unsigned CB_FLAG = 2;

   // service key halves
   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;

   typedef enum logic {
      KS_IDLE = 1'b0,
      KS_HALF = 1'b1
   } key_state_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 0) begin : g_bad_div
         $error("wdg_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         logic [PW-1:0] ph_q;
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ph_q <= '0;
            end else if (ph_q == LAST) begin
               ph_q <= '0;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
         end
         assign tick = (ph_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
   import wdg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_acc,
   input  logic       key_wr,
   input  logic [7:0] key_data,
   output logic       key_ok,
   output logic       key_bad
);
   key_state_t st_q, st_d;

   always_comb begin
      st_d    = st_q;
      key_ok  = 1'b0;
      key_bad = 1'b0;
      unique case (st_q)
         KS_IDLE: begin
            if (key_wr && key_data == KEY_FIRST) st_d = KS_HALF;
         end
         KS_HALF: begin
            if (bus_acc) st_d = KS_IDLE;
            if (key_wr) begin
               if (key_data == KEY_SECOND) key_ok = 1'b1;
               else                        key_bad = 1'b1;
            end
         end
         default: st_d = KS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= KS_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
   parameter int unsigned CNT_W = 24,
   parameter int unsigned RST_V = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] INIT = CNT_W'(RST_V);

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step   = run && tick && (cnt_q != '0);
   assign expire = step && !load && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= INIT;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
   import wdg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned CNT_W    = 24,
   parameter int unsigned PRESCALE = 4,
   parameter int unsigned MIN_TC   = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rst_req
);
   localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(MIN_TC);
   localparam int unsigned      PAD_CNT  = DATA_W - CNT_W;
   localparam int unsigned      PAD_CTRL = DATA_W - 3;

   generate
      if (CNT_W >= DATA_W) begin : g_chk_width
         $error("wdg_timer: CNT_W must be narrower than DATA_W");
      end
      if (CNT_W < 9) begin : g_chk_cnt
         $error("wdg_timer: CNT_W must hold the key and floor values");
      end
      if (ADDR_W < 2) begin : g_chk_addr
         $error("wdg_timer: ADDR_W must cover four registers");
      end
      if (MIN_TC == 0) begin : g_chk_floor
         $error("wdg_timer: MIN_TC must be nonzero");
      end
   endgenerate

   // address decode
   logic wr_ctrl, wr_tc, wr_key, bus_acc;
   assign wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
   assign wr_tc   = wr_en && (addr == ADDR_W'(REG_TC));
   assign wr_key  = wr_en && (addr == ADDR_W'(REG_KEY));
   assign bus_acc = wr_en || rd_en;

   // state
   logic             en_q, rsel_q, flag_q, armed_q;
   logic [CNT_W-1:0] tc_q;
   logic [CNT_W-1:0] count;
   logic             tick, expire, feed_ok, feed_bad, trip;
   logic [CNT_W-1:0] tc_in;

   wdg_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   wdg_key_seq u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_acc  (bus_acc),
      .key_wr   (wr_key),
      .key_data (wdata[7:0]),
      .key_ok   (feed_ok),
      .key_bad  (feed_bad)
   );

   wdg_downcount #(.CNT_W(CNT_W), .RST_V(MIN_TC)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (armed_q),
      .load     (feed_ok),
      .load_val (tc_q),
      .count    (count),
      .expire   (expire)
   );

   assign tc_in = (wdata[CNT_W-1:0] < TC_FLOOR) ? TC_FLOOR : wdata[CNT_W-1:0];
   assign trip  = armed_q && (expire || feed_bad);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         rsel_q  <= 1'b0;
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
         tc_q    <= TC_FLOOR;
         rst_req <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q   <= en_q   | wdata[CB_EN];
            rsel_q <= rsel_q | wdata[CB_RSEL];
         end
         if (wr_tc) tc_q <= tc_in;
         if (feed_ok && en_q) armed_q <= 1'b1;
         if (trip) flag_q <= 1'b1;
         rst_req <= trip && rsel_q;
      end
   end

   // readback
   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(REG_CTRL): rdata = {{PAD_CTRL{1'b0}}, flag_q, rsel_q, en_q};
         ADDR_W'(REG_TC):   rdata = {{PAD_CNT{1'b0}}, tc_q};
         ADDR_W'(REG_CNT):  rdata = {{PAD_CNT{1'b0}}, count};
         default:           rdata = '0;
      endcase
   end

   logic unused_hi;
   assign unused_hi = ^wdata[DATA_W-1:CNT_W];
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk #(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned MIN_TC = 255
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             rsel,
   input logic             flag,
   input logic             armed,
   input logic             rst_req,
   input logic             feed_ok,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] tconst
);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_TC);

   p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> en);
   p_rsel_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsel |=> rsel);
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag |=> flag);
   p_req_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> flag);
   p_req_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(rsel));
   p_live_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> en);
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !feed_ok) |=> $stable(count));
   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      feed_ok |=> count == $past(tconst));
   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !feed_ok) |=> (count == $past(count)) || (count == $past(count) - ONE));
   p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tconst >= FLOOR);
endmodule

bind wdg_timer wdg_timer_chk #(.CNT_W(CNT_W), .MIN_TC(MIN_TC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en_q),
   .rsel    (rsel_q),
   .flag    (flag_q),
   .armed   (armed_q),
   .rst_req (rst_req),
   .feed_ok (feed_ok),
   .count   (count),
   .tconst  (tc_q)
);

// File: tb/wdg_timer_bench.sv
module wdg_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic        rst_req;

   int n_chk = 0;
   int n_bad = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wdg_timer u_wdg_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
   );

   always @(negedge clk) if (rst_req) pulses++;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pulses = 0;
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
      rd_en = 1'b1; wr_en = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic feed();
      bus_wr(2'd2, 32'hAA);
      bus_wr(2'd2, 32'h55);
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      do_reset();
      peek(2'd0, v); chk("R1 ctrl", v, 32'h0);
      peek(2'd1, v); chk("R1 tconst", v, 32'hFF);
      peek(2'd3, v); chk("R1 count", v, 32'hFF);
      chk("R1 rst_req", {31'd0, rst_req}, 32'h0);
   endtask

   task automatic t_tconst();
      logic [31:0] v;
      do_reset();
      @(negedge clk);
      bus_wr(2'd1, 32'h10);        bus_rd(2'd1, v); chk("R2 floor", v, 32'hFF);
      bus_wr(2'd1, 32'hAB123456);  bus_rd(2'd1, v); chk("R2 upper ignored", v, 32'h123456);
      bus_wr(2'd1, 32'h100);       bus_rd(2'd1, v); chk("R2 plain", v, 32'h100);
      bus_rd(2'd2, v); chk("R11 key reads zero", v, 32'h0);
      bus_rd(2'd3, v); chk("R11 count zero-ext", v, 32'hFF);
   endtask

   task automatic t_sticky_ctrl();
      logic [31:0] v;
      do_reset();
      @(negedge clk);
      bus_wr(2'd0, 32'h4);  bus_rd(2'd0, v); chk("R3 flag not writable", v, 32'h0);
      bus_wr(2'd0, 32'h3);  bus_wr(2'd0, 32'h0);
      bus_rd(2'd0, v); chk("R3 set-only", v, 32'h3);
   endtask

   task automatic t_arm_and_run();
      logic [31:0] v, c0, c1;
      do_reset();
      @(negedge clk);
      bus_wr(2'd1, 32'h300);
      feed();
      peek(2'd3, v); chk("R6 reload while idle", v, 32'h300);
      bus_wr(2'd0, 32'h1);
      repeat (40) @(negedge clk);
      peek(2'd3, v); chk("R4 early key does not arm", v, 32'h300);
      feed();
      peek(2'd3, c0);
      repeat (40) @(negedge clk);
      peek(2'd3, c1);
      chk("R5 ten ticks in forty cycles", c0 - c1, 32'd10);
      feed();
      peek(2'd3, v); chk("R6 reload while live", v, 32'h300);
      // aborted sequence: key, read, second half
      repeat (20) @(negedge clk);
      bus_wr(2'd2, 32'hAA);
      bus_rd(2'd0, v);
      bus_wr(2'd2, 32'h55);
      peek(2'd3, v);
      chk("R10 aborted key does not reload", {31'd0, v < 32'h300}, 32'h1);
      peek(2'd0, v); chk("R10 aborted key does not trip", v, 32'h1);
      // aborted by a write to another register
      bus_wr(2'd2, 32'hAA);
      bus_wr(2'd1, 32'h300);
      bus_wr(2'd2, 32'h12);
      peek(2'd0, v); chk("R10 other write cancels", v, 32'h1);
   endtask

   task automatic t_expire(input bit with_rsel);
      logic [31:0] v;
      do_reset();
      @(negedge clk);
      bus_wr(2'd0, with_rsel ? 32'h3 : 32'h1);
      feed();
      repeat (1100) @(negedge clk);
      peek(2'd3, v); chk(with_rsel ? "R7 count held at zero" : "R8 count held at zero", v, 32'h0);
      peek(2'd0, v);
      chk(with_rsel ? "R7 flag set" : "R8 flag set", v[2], 1'b1);
      chk(with_rsel ? "R7 one pulse" : "R8 no pulse", pulses, with_rsel ? 32'd1 : 32'd0);
   endtask

   task automatic t_bad_key();
      logic [31:0] v;
      do_reset();
      @(negedge clk);
      bus_wr(2'd0, 32'h2);          // reset select only, not enabled
      bus_wr(2'd2, 32'hAA);
      bus_wr(2'd2, 32'h12);
      chk("R9 idle bad key no request", {31'd0, rst_req}, 32'h0);
      peek(2'd0, v); chk("R9 idle bad key no flag", v, 32'h2);
      bus_wr(2'd0, 32'h1);
      feed();
      bus_wr(2'd2, 32'hAA);
      bus_wr(2'd2, 32'h12);
      chk("R9 live bad key request", {31'd0, rst_req}, 32'h1);
      peek(2'd0, v); chk("R9 live bad key flag", v, 32'h7);
      @(negedge clk);
      chk("R9 request single cycle", {31'd0, rst_req}, 32'h0);
      chk("R9 pulse count", pulses, 32'd1);
   endtask

   initial begin
      t_reset_state();
      t_tconst();
      t_sticky_ctrl();
      t_arm_and_run();
      t_expire(1'b1);
      t_expire(1'b0);
      t_bad_key();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule